// File: doc/BRIEF.md
# Two-Wire Target with Auto-Incrementing 64-Byte Register Space

This block is the bus-facing part of a timekeeping chip. It watches the two wires of an I2C bus, sampled into a fast system clock, and acts as a target at one fixed 7-bit address. Behind it sits a 64-byte space. Bytes 0 to 6 are the time-of-day registers, byte 7 is the control register, and bytes 8 to 63 are plain RAM. Here all 64 are modelled as ordinary storage that clears on reset.

Every access goes through a 6-bit word pointer. In a write, the master sends the target address with R/W low, then a word address, then any number of data bytes. A read may follow a word-address write after a repeated START. A read may also start directly with the read address, and then it continues from wherever the pointer was left. A power-fail input ends any transfer at once, clears the pointer, and makes the block deaf to the bus while it is asserted. The SDA output is an open-drain pull-down enable.

Top module: `i2c_regfile_target`

## Requirements
- R1: Out of reset SDA is released, all 64 bytes read as 0x00, and a read without a word address returns byte 0.
- R2: Only address byte 0xD0 (write) or 0xD1 (read) is acknowledged, i.e. 7-bit address 1101000 followed by R/W. Any other address gets no acknowledge, and the bytes that follow it change no storage.
- R3: In a write transfer, the target pulls SDA low in the ninth clock after the address, after the word address and after every data byte. Data byte k after the word address W is stored at (W+k) mod 64.
- R4: After a word-address write, a repeated START and address 0xD1, bytes are sent MSB first, starting at the word address and going up.
- R5: During a read the pointer advances only on a master acknowledge. After a NACK the target releases SDA and the pointer stays at the last byte sent.
- R6: A read that begins with 0xD1 and no word address starts at the current pointer, which a previous write left one past its last stored byte.
- R7: The pointer wraps from 63 to 0 in both writes and reads.
- R8: While power-fail is high, SDA is released within one cycle, the pointer is 0, no byte is acknowledged and no storage changes. After it drops, reads start at byte 0.
- R9: The target never changes its SDA drive while SCL is high. After a STOP it leaves SDA released and ignores bytes until the next START.
- R10: Only the low 6 bits of the word address are used. Word 0xC9 selects byte 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Active-low synchronous reset |
| powerFail | input | 1 | High while supply is out of tolerance; aborts and resets the pointer |
| sclIn | input | 1 | Bus clock line as seen at the pin |
| sdaIn | input | 1 | Bus data line as seen at the pin (wired-AND level) |
| sdaDriveLow | output | 1 | High pulls SDA low; low releases it |

## Verification
The main function is tried with three patterns. Short bursts at an odd word address show whether the word byte and the data bytes go to the right places. A full 64-byte write followed by a 66-byte read across the top of the space shows whether the pointer wraps and whether it moves in reads. Reads with and without a word address, ended by a NACK, tell an increment on acknowledge apart from an increment on every byte. A sweep of all 127 foreign addresses, a byte sent without START, and a write attempted under power-fail each show that storage and pointer are left alone when the target must stay silent.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_WORD,
    ST_WDATA,
    ST_RDATA
  } busState_t;

  typedef struct packed {
    logic shiftIn;
    logic loadPtr;
    logic writeMem;
    logic incPtr;
    logic loadTx;
    logic shiftTx;
    logic clrPtr;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_rf_sync.sv
module i2c_rf_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclS,
  output logic sdaS,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sclPipe, sdaPipe;
  logic sclD, sdaD;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclD    <= 1'b1;
      sdaD    <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[LAST-1:0], sclIn};
      sdaPipe <= {sdaPipe[LAST-1:0], sdaIn};
      sclD    <= sclPipe[LAST];
      sdaD    <= sdaPipe[LAST];
    end
  end

  assign sclS     = sclPipe[LAST];
  assign sdaS     = sdaPipe[LAST];
  assign sclRise  = sclS & ~sclD;
  assign sclFall  = ~sclS & sclD;
  assign startDet = sclS & sclD & sdaD & ~sdaS;
  assign stopDet  = sclS & sclD & ~sdaD & sdaS;
endmodule

// File: rtl/i2c_rf_ctrl.sv
module i2c_rf_ctrl
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h68
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       powerFail,
  input  logic       sdaS,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic [7:0] rxByte,
  output dpStrobe_t  strb,
  output logic       ackDrive,
  output logic       txEn
);
  busState_t state, stateN;
  logic [3:0] bitCnt, bitCntN;
  logic inAck, inAckN, rwBit, rwN, ackN, txN;

  always_comb begin
    stateN  = state;
    bitCntN = bitCnt;
    inAckN  = inAck;
    rwN     = rwBit;
    ackN    = ackDrive;
    txN     = txEn;
    strb    = '0;
    if (powerFail) begin
      stateN      = ST_IDLE;
      inAckN      = 1'b0;
      ackN        = 1'b0;
      txN         = 1'b0;
      strb.clrPtr = 1'b1;
    end else if (startDet) begin
      stateN  = ST_ADDR;
      bitCntN = '0;
      inAckN  = 1'b0;
      ackN    = 1'b0;
      txN     = 1'b0;
    end else if (stopDet) begin
      stateN = ST_IDLE;
      inAckN = 1'b0;
      ackN   = 1'b0;
      txN    = 1'b0;
    end else begin
      case (state)
        ST_ADDR, ST_WORD, ST_WDATA: begin
          if (!inAck) begin
            if (sclRise && bitCnt != 4'd8) begin
              strb.shiftIn = 1'b1;
              bitCntN      = bitCnt + 4'd1;
            end else if (sclFall && bitCnt == 4'd8) begin
              ackN   = 1'b1;
              inAckN = 1'b1;
              if (state == ST_ADDR) begin
                rwN = rxByte[0];
                if (rxByte[7:1] != TARGET_ADDR) begin
                  ackN   = 1'b0;
                  inAckN = 1'b0;
                  stateN = ST_IDLE;
                end
              end else if (state == ST_WORD) begin
                strb.loadPtr = 1'b1;
              end else begin
                strb.writeMem = 1'b1;
              end
            end
          end else if (sclFall) begin
            ackN    = 1'b0;
            inAckN  = 1'b0;
            bitCntN = '0;
            if (state == ST_ADDR) begin
              if (rwBit) begin
                stateN      = ST_RDATA;
                strb.loadTx = 1'b1;
                txN         = 1'b1;
              end else begin
                stateN = ST_WORD;
              end
            end else if (state == ST_WORD) begin
              stateN = ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (!inAck) begin
            if (sclFall) begin
              if (bitCnt == 4'd7) begin
                txN     = 1'b0;
                inAckN  = 1'b1;
                bitCntN = '0;
              end else begin
                strb.shiftTx = 1'b1;
                bitCntN      = bitCnt + 4'd1;
              end
            end
          end else if (sclRise) begin
            if (sdaS) begin
              stateN = ST_IDLE;
              inAckN = 1'b0;
            end else begin
              strb.incPtr = 1'b1;
            end
          end else if (sclFall) begin
            strb.loadTx = 1'b1;
            txN         = 1'b1;
            inAckN      = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      inAck    <= 1'b0;
      rwBit    <= 1'b0;
      ackDrive <= 1'b0;
      txEn     <= 1'b0;
    end else begin
      state    <= stateN;
      bitCnt   <= bitCntN;
      inAck    <= inAckN;
      rwBit    <= rwN;
      ackDrive <= ackN;
      txEn     <= txN;
    end
  end
endmodule

// File: rtl/i2c_rf_data.sv
module i2c_rf_data
  import i2c_rf_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  dpStrobe_t                strb,
  input  logic                     sdaS,
  output logic [7:0]               rxByte,
  output logic                     txBit,
  output logic [$clog2(DEPTH)-1:0] ptr
);
  localparam int PW = $clog2(DEPTH);

  logic [7:0] mem [DEPTH];
  logic [7:0] txShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr     <= '0;
      rxByte  <= '0;
      txShift <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (strb.shiftIn) rxByte <= {rxByte[6:0], sdaS};
      if (strb.clrPtr) begin
        ptr <= '0;
      end else if (strb.loadPtr) begin
        ptr <= rxByte[PW-1:0];
      end else if (strb.writeMem) begin
        mem[ptr] <= rxByte;
        ptr      <= ptr + PW'(1);
      end else if (strb.incPtr) begin
        ptr <= ptr + PW'(1);
      end
      if (strb.loadTx) txShift <= mem[ptr];
      else if (strb.shiftTx) txShift <= {txShift[6:0], 1'b0};
    end
  end

  assign txBit = txShift[7];
endmodule

// File: rtl/i2c_regfile_target.sv
module i2c_regfile_target
  import i2c_rf_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h68,
  parameter int         DEPTH       = 64,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic powerFail,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaDriveLow
);
  localparam int PTR_W = $clog2(DEPTH);

  logic sclS, sdaS, sclRise, sclFall, startDet, stopDet;
  logic ackDrive, txEn, txBit;
  logic [7:0] rxByte;
  logic [PTR_W-1:0] ptr;
  dpStrobe_t strb;

  i2c_rf_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclS(sclS), .sdaS(sdaS), .sclRise(sclRise), .sclFall(sclFall),
    .startDet(startDet), .stopDet(stopDet)
  );

  i2c_rf_ctrl #(.TARGET_ADDR(TARGET_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .powerFail(powerFail), .sdaS(sdaS),
    .sclRise(sclRise), .sclFall(sclFall), .startDet(startDet),
    .stopDet(stopDet), .rxByte(rxByte), .strb(strb),
    .ackDrive(ackDrive), .txEn(txEn)
  );

  i2c_rf_data #(.DEPTH(DEPTH)) u_data (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaS(sdaS),
    .rxByte(rxByte), .txBit(txBit), .ptr(ptr)
  );

  assign sdaDriveLow = ackDrive | (txEn & ~txBit);
endmodule

// File: rtl/i2c_rf_chk.sv
module i2c_rf_chk
  import i2c_rf_pkg::*;
#(
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rstN,
  input logic          powerFail,
  input logic          sclS,
  input logic          sdaDriveLow,
  input dpStrobe_t     strb,
  input logic [PW-1:0] ptr
);
  // R8
  pfail_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |=> !sdaDriveLow);

  // R8
  pfail_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerFail |=> ptr == '0);

  // R3 R5 R7
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN || powerFail)
    (strb.incPtr || strb.writeMem) |=> ptr == PW'($past(ptr) + PW'(1)));

  // R5
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN || powerFail)
    (!strb.incPtr && !strb.writeMem && !strb.loadPtr && !strb.clrPtr) |=> $stable(ptr));

  // R9
  scl_high_stable_chk: assert property (@(posedge clk) disable iff (!rstN || powerFail)
    (sclS && $past(sclS) && !$past(powerFail)) |-> $stable(sdaDriveLow));
endmodule

bind i2c_regfile_target i2c_rf_chk #(.PW(PTR_W)) u_chk (
  .clk(clk), .rstN(rstN), .powerFail(powerFail), .sclS(sclS),
  .sdaDriveLow(sdaDriveLow), .strb(strb), .ptr(ptr)
);

// File: tb/i2c_regfile_target_tb.sv
module i2c_regfile_target_tb;
  localparam int Q = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic powerFail = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaDriveLow;
  wire  sdaLine = sdaM & ~sdaDriveLow;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [7:0] exp [64];

  i2c_regfile_target u_dut (
    .clk(clk), .rstN(rstN), .powerFail(powerFail),
    .sclIn(sclM), .sdaIn(sdaLine), .sdaDriveLow(sdaDriveLow)
  );

  always #2 clk = ~clk;

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, expv);
    end
  endtask

  task automatic busStart();
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b0; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic busStop();
    sdaM = 1'b0; tick(Q);
    sclM = 1'b1; tick(Q);
    sdaM = 1'b1; tick(Q);
    chk(sdaDriveLow == 1'b0, "R9 released after stop", sdaDriveLow, 0);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; tick(Q);
      sclM = 1'b1; tick(2 * Q);
      sclM = 1'b0; tick(Q);
    end
    sdaM = 1'b1; tick(Q);
    sclM = 1'b1; tick(Q);
    ack = ~sdaLine; tick(Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic recvByte(input bit mack, output logic [7:0] b);
    sdaM = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      sclM = 1'b1; tick(Q);
      b[i] = sdaLine; tick(Q);
      sclM = 1'b0;
    end
    tick(Q);
    sdaM = ~mack; tick(Q);
    sclM = 1'b1; tick(2 * Q);
    sclM = 1'b0; tick(Q);
  endtask

  task automatic rdRun(input int base, input int n, input string req);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      recvByte(i != n - 1, d);
      chk(d == exp[(base + i) & 63], req, d, exp[(base + i) & 63]);
    end
  endtask

  task automatic wrAt(input logic [7:0] word, input int n, input int seed, input string req);
    bit a;
    logic [7:0] d;
    int base;
    base = int'(word) & 63;
    busStart();
    sendByte(8'hD0, a); chk(a, req, a, 1);
    sendByte(word, a);  chk(a, req, a, 1);
    for (int i = 0; i < n; i++) begin
      d = 8'(seed + i * 37);
      sendByte(d, a); chk(a, req, a, 1);
      exp[(base + i) & 63] = d;
    end
    busStop();
  endtask

  task automatic rdAt(input int word, input int n, input string req);
    bit a;
    busStart();
    sendByte(8'hD0, a);        chk(a, req, a, 1);
    sendByte(8'(word), a);     chk(a, req, a, 1);
    busStart();
    sendByte(8'hD1, a);        chk(a, req, a, 1);
    rdRun(word & 63, n, req);
    busStop();
  endtask

  task automatic rdCur(input int base, input int n, input string req);
    bit a;
    busStart();
    sendByte(8'hD1, a); chk(a, req, a, 1);
    rdRun(base, n, req);
    busStop();
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit a;
    for (int i = 0; i < 64; i++) exp[i] = 8'h00;
    tick(5);
    rstN = 1'b1;
    tick(4);
    // R1 reset state and first current-address read
    chk(sdaDriveLow == 1'b0, "R1 sda released", sdaDriveLow, 0);
    rdCur(0, 1, "R1 read at byte 0");

    // R3 write burst at odd word address; R6 pointer left after it
    wrAt(8'd5, 6, 8'hA1, "R3 write burst ack");
    rdCur(11, 1, "R6 current read after write");

    // R4 combined read; R5 no increment on NACK
    rdAt(5, 4, "R4 combined read");
    rdCur(8, 2, "R5 pointer holds after nack");

    // R7 full sweep with wrap in write and read
    wrAt(8'd0, 64, 8'h11, "R7 full write");
    rdCur(0, 1, "R7 write wrapped to 0");
    rdAt(62, 66, "R7 read wrap");

    // R10 upper bits of word address ignored
    wrAt(8'hC9, 1, 8'h5A, "R10 word upper bits");
    rdAt(9, 1, "R10 readback byte 9");

    // R2 all foreign addresses rejected
    for (int ad = 0; ad < 128; ad++) begin
      if (ad != 8'h68) begin
        busStart();
        sendByte(8'(ad << 1), a);
        chk(!a, "R2 foreign address nack", a, 0);
        busStop();
      end
    end
    busStart();
    sendByte(8'hD2, a); chk(!a, "R2 foreign addr", a, 0);
    sendByte(8'h00, a); chk(!a, "R2 word ignored", a, 0);
    sendByte(8'hEE, a); chk(!a, "R2 data ignored", a, 0);
    busStop();
    rdAt(0, 1, "R2 storage unchanged");

    // R9 byte with no START is ignored
    sendByte(8'hD0, a); chk(!a, "R9 no start no ack", a, 0);
    busStop();

    // R8 power fail abort and lockout
    busStart();
    sendByte(8'hD0, a); chk(a, "R8 pre addr", a, 1);
    sendByte(8'd20, a); chk(a, "R8 pre word", a, 1);
    sendByte(8'h3C, a); chk(a, "R8 pre data", a, 1);
    exp[20] = 8'h3C;
    powerFail = 1'b1;
    tick(2);
    chk(sdaDriveLow == 1'b0, "R8 released", sdaDriveLow, 0);
    sendByte(8'h99, a); chk(!a, "R8 aborted byte", a, 0);
    busStop();
    busStart();
    sendByte(8'hD0, a); chk(!a, "R8 addr ignored", a, 0);
    sendByte(8'd30, a); chk(!a, "R8 word ignored", a, 0);
    sendByte(8'h77, a); chk(!a, "R8 data ignored", a, 0);
    busStop();
    powerFail = 1'b0;
    tick(4);
    rdCur(0, 1, "R8 pointer reset");
    rdAt(20, 1, "R8 byte before abort kept");
    rdAt(30, 1, "R8 no write under power fail");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule